// File: doc/BRIEF.md
# Frame Preemption Verify Controller

This block runs the handshake a MAC must complete before it may fragment express-interrupted traffic toward its link partner. An apply command arms the controller. It then requests a verify frame from the transmit path. When the transmit path acknowledges the request, a millisecond timer starts. A response frame reported by the receive path before the timer expires marks the link as verified and raises the preemption enable.

If the timer runs out first, another verify frame is requested. This repeats until a bounded number of attempts is used up. The controller then parks in a failed state that only a new apply command can leave. A disable command drops the controller back to its idle initial state at any time, except from the failed state. The block only decides when frames are needed. Building and sending them is left to the surrounding MAC.

Top module: `fpv_verify_ctrl`

## Requirements
- R1: After reset the status output reads 0 (initial), the preemption enable is low and no send request is raised.
- R2: Status encoding is 0 = initial, 1 = verifying, 2 = succeeded, 3 = failed. An apply pulse, from any state, reloads the attempt budget, puts the status at 0 and raises the send request from the following cycle.
- R3: A cycle in which the send request and the send acknowledge are both high moves the status to 1 on the next cycle and drops the send request.
- R4: A response pulse while the status is 1 moves the status to 2 and raises the preemption enable on the next cycle. The enable is high only while the status is 2.
- R5: The wait is counted in millisecond tick pulses seen after the acknowledge. With a verify time of N, the status is still 1 after N-1 ticks, and the N-th tick ends the attempt.
- R6: An attempt that times out with budget left returns the status to 0 and requests a new verify frame. Each apply allows LIMIT requests in total (default 3).
- R7: When the last attempt times out, the status becomes 3, the preemption enable stays low and no further send request is raised.
- R8: In status 3, response pulses, ticks and disable pulses change nothing. Only an apply pulse leaves that state.
- R9: A disable pulse in status 0, 1 or 2 sets the status to 0, clears the preemption enable, stops the timer and suppresses send requests until the next apply.
- R10: Response pulses arriving while the status is 0 or 2 are ignored.
- R11: The programmed verify time is limited to MAX_MS (default 128). A value of 0 is treated as 1.
- R12: A response pulse in the same cycle as the tick that would end the final attempt gives status 2, not status 3.
- R13: When disable and apply arrive in the same cycle, disable takes priority and no send request follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| apply_i | input | 1 | Pulse: start a fresh verification |
| disable_i | input | 1 | Pulse: stop verification and drop preemption |
| resp_i | input | 1 | Pulse: a verify response frame was received |
| ms_tick_i | input | 1 | One-cycle pulse once per millisecond |
| verify_ms_i | input | TIME_W | Programmed verify time in milliseconds |
| send_ack_i | input | 1 | Transmit path accepted the verify frame request |
| send_req_o | output | 1 | Request to transmit one verify frame |
| status_o | output | 2 | Verification status, encoded as in R2 |
| preempt_en_o | output | 1 | Preemption may be used toward the partner |

## Verification
Two events can meet in one cycle. The first pair is the response pulse and the millisecond tick that ends the last attempt. The second pair is a disable pulse and an apply pulse. The bench drives the final tick and the response on the same clock edge and expects success with the enable raised, rather than failure. It also drives apply and disable together from the succeeded state and expects the initial state with no send request afterward. A scoreboard queue holds every expected status transition in order, so a wrong winner in either collision shows up as a mismatched or extra transition.

// File: rtl/fpv_pkg.sv
package fpv_pkg;
   typedef enum logic [1:0] {
      FPV_INIT   = 2'd0,
      FPV_VERIFY = 2'd1,
      FPV_OK     = 2'd2,
      FPV_FAIL   = 2'd3
   } fpv_state_e;
endpackage

// File: rtl/fpv_time_sel.sv
module fpv_time_sel #(
   parameter int TIME_W   = 8,
   parameter int MAX_MS   = 128,
   parameter bit CLAMP_EN = 1'b1
) (
   input  logic [TIME_W-1:0] raw_i,
   output logic [TIME_W-1:0] eff_o
);
   localparam logic [TIME_W-1:0] MAX_V = TIME_W'(MAX_MS);
   localparam logic [TIME_W-1:0] ONE_V = TIME_W'(1);

   if (MAX_MS < 1 || MAX_MS >= (1 << TIME_W)) begin : g_bad_cfg
      $error("fpv_time_sel: MAX_MS must fit in TIME_W bits and be at least 1");
   end

   if (CLAMP_EN) begin : g_clamp
      always_comb begin
         if (raw_i == '0)        eff_o = ONE_V;
         else if (raw_i > MAX_V) eff_o = MAX_V;
         else                    eff_o = raw_i;
      end
   end else begin : g_pass
      always_comb begin
         eff_o = (raw_i == '0) ? ONE_V : raw_i;
      end
   end
endmodule

// File: rtl/fpv_timer.sv
module fpv_timer #(
   parameter int TIME_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              arm_i,
   input  logic              stop_i,
   input  logic              tick_i,
   input  logic [TIME_W-1:0] len_i,
   output logic              expire_o
);
   logic              run_q;
   logic [TIME_W-1:0] cnt_q;
   logic [TIME_W-1:0] len_q;
   logic              at_end;

   assign at_end   = (cnt_q == (len_q - 1'b1));
   assign expire_o = run_q & tick_i & at_end;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q <= 1'b0;
         cnt_q <= '0;
         len_q <= TIME_W'(1);
      end else if (arm_i) begin
         run_q <= 1'b1;
         cnt_q <= '0;
         len_q <= len_i;
      end else if (stop_i) begin
         run_q <= 1'b0;
      end else if (run_q && tick_i) begin
         if (at_end) run_q <= 1'b0;
         else        cnt_q <= cnt_q + 1'b1;
      end
   end
endmodule

// File: rtl/fpv_attempts.sv
module fpv_attempts #(
   parameter int LIMIT = 3,
   parameter int CNT_W = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic load_i,
   input  logic dec_i,
   output logic last_o
);
   logic [CNT_W-1:0] left_q;

   if (LIMIT < 1 || LIMIT >= (1 << CNT_W)) begin : g_bad_cfg
      $error("fpv_attempts: LIMIT must be at least 1 and fit in CNT_W bits");
   end

   assign last_o = (left_q <= CNT_W'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 left_q <= CNT_W'(LIMIT);
      else if (load_i)            left_q <= CNT_W'(LIMIT);
      else if (dec_i && !last_o)  left_q <= left_q - 1'b1;
   end
endmodule

// File: rtl/fpv_verify_ctrl.sv
module fpv_verify_ctrl #(
   parameter int TIME_W   = 8,
   parameter int MAX_MS   = 128,
   parameter int LIMIT    = 3,
   parameter bit CLAMP_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              apply_i,
   input  logic              disable_i,
   input  logic              resp_i,
   input  logic              ms_tick_i,
   input  logic [TIME_W-1:0] verify_ms_i,
   input  logic              send_ack_i,
   output logic              send_req_o,
   output logic [1:0]        status_o,
   output logic              preempt_en_o
);
   import fpv_pkg::*;

   localparam int CNT_W = $clog2(LIMIT + 1);

   fpv_state_e        state_q, state_d;
   logic              run_q, run_d;
   logic              en_q;
   logic [TIME_W-1:0] eff_ms;
   logic              expire;
   logic              arm, stop;
   logic              load_att, dec_att, last_att;

   fpv_time_sel #(.TIME_W(TIME_W), .MAX_MS(MAX_MS), .CLAMP_EN(CLAMP_EN)) u_sel (
      .raw_i (verify_ms_i),
      .eff_o (eff_ms)
   );

   fpv_timer #(.TIME_W(TIME_W)) u_tmr (
      .clk      (clk),
      .rst_n    (rst_n),
      .arm_i    (arm),
      .stop_i   (stop),
      .tick_i   (ms_tick_i),
      .len_i    (eff_ms),
      .expire_o (expire)
   );

   fpv_attempts #(.LIMIT(LIMIT), .CNT_W(CNT_W)) u_att (
      .clk    (clk),
      .rst_n  (rst_n),
      .load_i (load_att),
      .dec_i  (dec_att),
      .last_o (last_att)
   );

   // priority: disable, apply, response, timer expiry
   always_comb begin
      state_d  = state_q;
      run_d    = run_q;
      arm      = 1'b0;
      load_att = 1'b0;
      dec_att  = 1'b0;
      if (disable_i && state_q != FPV_FAIL) begin
         state_d = FPV_INIT;
         run_d   = 1'b0;
      end else if (disable_i) begin
         state_d = FPV_FAIL;
      end else if (apply_i) begin
         state_d  = FPV_INIT;
         run_d    = 1'b1;
         load_att = 1'b1;
      end else begin
         unique case (state_q)
            FPV_INIT: begin
               if (run_q && send_ack_i) begin
                  state_d = FPV_VERIFY;
                  arm     = 1'b1;
               end
            end
            FPV_VERIFY: begin
               if (resp_i) begin
                  state_d = FPV_OK;
               end else if (expire) begin
                  if (last_att) begin
                     state_d = FPV_FAIL;
                     run_d   = 1'b0;
                  end else begin
                     state_d = FPV_INIT;
                     dec_att = 1'b1;
                  end
               end
            end
            default: ;
         endcase
      end
   end

   assign stop = (state_q == FPV_VERIFY) && (state_d != FPV_VERIFY);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= FPV_INIT;
         run_q   <= 1'b0;
         en_q    <= 1'b0;
      end else begin
         state_q <= state_d;
         run_q   <= run_d;
         en_q    <= (state_d == FPV_OK);
      end
   end

   assign send_req_o   = run_q && (state_q == FPV_INIT);
   assign status_o     = state_q;
   assign preempt_en_o = en_q;
endmodule

// File: rtl/fpv_verify_chk.sv
module fpv_verify_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       apply_i,
   input logic       disable_i,
   input logic       resp_i,
   input logic       send_ack_i,
   input logic       send_req_o,
   input logic [1:0] status_o,
   input logic       preempt_en_o
);
   import fpv_pkg::*;

   AST_APPLY_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      apply_i && !disable_i |=> send_req_o && status_o == FPV_INIT); // R2

   AST_ACK_ARMS: assert property (@(posedge clk) disable iff (!rst_n)
      send_req_o && send_ack_i && !disable_i && !apply_i |=> status_o == FPV_VERIFY && !send_req_o); // R3

   AST_RESP_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      status_o == FPV_VERIFY && resp_i && !disable_i && !apply_i |=> status_o == FPV_OK && preempt_en_o); // R4

   AST_EN_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(preempt_en_o) |-> $past(status_o) == FPV_VERIFY); // R4

   AST_NO_SEND_FAIL: assert property (@(posedge clk) disable iff (!rst_n)
      status_o == FPV_FAIL |-> !send_req_o && !preempt_en_o); // R7

   AST_FAIL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      status_o == FPV_FAIL && !apply_i |=> status_o == FPV_FAIL); // R8

   AST_DISABLE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      disable_i && status_o != FPV_FAIL |=> status_o == FPV_INIT && !preempt_en_o && !send_req_o); // R9

   AST_RESP_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      status_o == FPV_INIT && resp_i && !apply_i && !disable_i && !(send_req_o && send_ack_i)
      |=> status_o == FPV_INIT); // R10
endmodule

bind fpv_verify_ctrl fpv_verify_chk u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .apply_i      (apply_i),
   .disable_i    (disable_i),
   .resp_i       (resp_i),
   .send_ack_i   (send_ack_i),
   .send_req_o   (send_req_o),
   .status_o     (status_o),
   .preempt_en_o (preempt_en_o)
);

// File: tb/tb_fpv_verify_ctrl.sv
module tb_fpv_verify_ctrl;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       apply = 1'b0, dis = 1'b0, resp = 1'b0, tick = 1'b0, ack = 1'b0;
   logic [7:0] vms = 8'd100;
   logic       send_req, en;
   logic [1:0] status;

   int errors = 0;
   int checks = 0;
   int sends  = 0;
   int s0;
   logic [1:0] expq[$];
   logic [1:0] last_st = 2'd0;

   always #10 clk = ~clk;

   fpv_verify_ctrl dut (
      .clk          (clk),
      .rst_n        (rst_n),
      .apply_i      (apply),
      .disable_i    (dis),
      .resp_i       (resp),
      .ms_tick_i    (tick),
      .verify_ms_i  (vms),
      .send_ack_i   (ack),
      .send_req_o   (send_req),
      .status_o     (status),
      .preempt_en_o (en)
   );

   task automatic chk(string req, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s act=%0d exp=%0d", req, act, exp);
      end
   endtask

   // transmit path model: accept every request one cycle after it is seen
   always @(negedge clk) begin
      if (!rst_n) ack <= 1'b0;
      else begin
         ack <= send_req;
         if (send_req) sends++;
      end
   end

   // scoreboard monitor: every status change must match the queue head
   always @(negedge clk) begin
      if (rst_n && status !== last_st) begin
         if (expq.size() == 0) chk("R6 scoreboard unexpected change", int'(status), int'(last_st));
         else begin
            logic [1:0] e;
            e = expq.pop_front();
            chk("R6 scoreboard transition", int'(status), int'(e));
         end
         chk("R4 enable follows status", int'(en), int'(status == 2'd2));
         last_st = status;
      end
   end

   task automatic idle(int n);
      repeat (n) @(negedge clk);
   endtask
   task automatic do_apply(logic [7:0] v);
      @(negedge clk); vms = v; apply = 1'b1;
      @(negedge clk); apply = 1'b0;
   endtask
   task automatic do_disable();
      @(negedge clk); dis = 1'b1;
      @(negedge clk); dis = 1'b0;
   endtask
   task automatic do_resp();
      @(negedge clk); resp = 1'b1;
      @(negedge clk); resp = 1'b0;
   endtask
   task automatic do_ticks(int n);
      repeat (n) begin
         @(negedge clk); tick = 1'b1;
         @(negedge clk); tick = 1'b0;
      end
   endtask
   task automatic push(logic [1:0] s);
      expq.push_back(s);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired act=0 exp=1");
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
   end

   initial begin
      idle(3);
      rst_n = 1'b1;
      idle(2);
      chk("R1 reset status", int'(status), 0);
      chk("R1 reset enable", int'(en), 0);
      chk("R1 reset send request", int'(send_req), 0);

      // basic success with verify time 5
      s0 = sends;
      push(2'd1);
      do_apply(8'd5);
      idle(3);
      chk("R2 one request after apply", sends - s0, 1);
      chk("R3 verifying after ack", int'(status), 1);
      do_ticks(4);
      chk("R5 still verifying after N-1 ticks", int'(status), 1);
      push(2'd2);
      do_resp();
      chk("R4 succeeded", int'(status), 2);
      chk("R4 enable raised", int'(en), 1);

      // response and ticks in succeeded state
      do_resp();
      do_ticks(10);
      chk("R10 response in succeeded ignored", int'(status), 2);

      // disable, then response in initial
      s0 = sends;
      push(2'd0);
      do_disable();
      chk("R9 disable to initial", int'(status), 0);
      chk("R9 disable clears enable", int'(en), 0);
      idle(5);
      do_resp();
      do_ticks(6);
      chk("R10 response in initial ignored", int'(status), 0);
      chk("R9 no request after disable", sends - s0, 0);

      // three timeouts lead to failed
      s0 = sends;
      push(2'd1); push(2'd0); push(2'd1); push(2'd0); push(2'd1); push(2'd3);
      do_apply(8'd3);
      idle(3);
      do_ticks(2);
      chk("R5 verifying after 2 of 3 ticks", int'(status), 1);
      do_ticks(1);
      idle(3);
      chk("R6 retry back to verifying", int'(status), 1);
      chk("R6 second request", sends - s0, 2);
      do_ticks(3);
      idle(3);
      do_ticks(3);
      idle(2);
      chk("R7 failed after limit", int'(status), 3);
      chk("R7 exactly three requests", sends - s0, 3);
      chk("R7 enable low", int'(en), 0);

      // failed is sticky
      s0 = sends;
      do_resp();
      do_ticks(5);
      do_disable();
      idle(3);
      chk("R8 failed sticky", int'(status), 3);
      chk("R8 no request while failed", sends - s0, 0);

      // apply leaves failed; budget reloaded; response meets final tick
      s0 = sends;
      push(2'd0); push(2'd1); push(2'd0); push(2'd1); push(2'd0); push(2'd1); push(2'd2);
      do_apply(8'd3);
      idle(3);
      do_ticks(3);
      idle(3);
      do_ticks(3);
      idle(3);
      do_ticks(2);
      @(negedge clk); tick = 1'b1; resp = 1'b1;
      @(negedge clk); tick = 1'b0; resp = 1'b0;
      chk("R12 response beats final expiry", int'(status), 2);
      chk("R12 enable raised", int'(en), 1);
      chk("R6 budget reloaded on apply", sends - s0, 3);

      // apply and disable in the same cycle
      s0 = sends;
      push(2'd0);
      @(negedge clk); apply = 1'b1; dis = 1'b1;
      @(negedge clk); apply = 1'b0; dis = 1'b0;
      idle(4);
      chk("R13 disable wins status", int'(status), 0);
      chk("R13 no request", sends - s0, 0);

      // clamp to 128
      s0 = sends;
      push(2'd1); push(2'd0); push(2'd1);
      do_apply(8'd200);
      idle(3);
      do_ticks(127);
      chk("R11 verifying after 127 ticks", int'(status), 1);
      do_ticks(1);
      idle(3);
      chk("R11 clamped expiry retried", sends - s0, 2);
      push(2'd0);
      do_disable();
      idle(2);

      // zero treated as one
      s0 = sends;
      push(2'd1); push(2'd0); push(2'd1);
      do_apply(8'd0);
      idle(3);
      do_ticks(1);
      idle(3);
      chk("R11 zero time expires on first tick", sends - s0, 2);
      push(2'd0);
      do_disable();
      idle(3);
      chk("R6 scoreboard drained", expq.size(), 0);

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule